// File: doc/BRIEF.md
# Pin I/O Controller with Level and Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 pins. Software reads and writes 32-bit registers through single-cycle read and write strobes. For each pin it sets the direction, the output enable and the output value, and it can read back the synchronized pin level. A per-pin bypass bit hands the pad driver to an alternate function, which is modelled as a plain pair of input vectors.

Every pin can also raise an interrupt. A pin can be level sensitive (high or low) or edge sensitive (rising, falling or both). Detected events latch into a status register, and reading that register clears it. There is no acknowledge register. Masking is controlled by two write-one strobes, one that unmasks and one that masks, and the resulting mask can be read back. The single interrupt output is raised when any pending status bit is unmasked.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, direction reads all ones for the implemented pins, the mask reads all ones, and bypass, output enable, output value, type, polarity, any-edge and status read zero. The interrupt output is low and no pad is driven.
- R2: The word addresses (byte address divided by 4) are: bypass 0, direction 1, output enable 2, output value 3, input 4, mask 5, unmask strobe 6, mask strobe 7, status 8, type 9, polarity 10, any-edge 11. The read/write registers return what was written. Bits at or above NUM_LINES read zero and ignore writes. The two strobe words read zero.
- R3: With bypass 0, a pad is driven (pad_oe=1) only when its direction bit is 0 and its output-enable bit is 1. The pad_out value is the output-value bit. The output-enable bit has no effect while the direction bit is 1.
- R4: With bypass 1, pad_out and pad_oe of that pin follow alt_out and alt_oe.
- R5: The input word returns pin_in after a two-flop synchronizer. A change at the pin is not visible before the second rising clock edge and is visible after it.
- R6: Writing a 1 to a bit of the unmask word clears that mask bit, and writing a 1 to a bit of the mask word sets it. Zero bits leave the mask unchanged.
- R7: Status bits latch whether or not the pin is masked. The interrupt output is high exactly when some status bit is set and its mask bit is 0.
- R8: A status read returns the pending bits and clears all of them in the same clock. An event detected in that same clock is kept. A level that is still active sets its bit again.
- R9: Type bit 1 selects level sensitivity, with polarity 1 meaning active-high and 0 meaning active-low. The status bit sets on every clock while the level is active.
- R10: Type bit 0 selects edge sensitivity. Polarity 1 selects the rising edge and 0 the falling edge, and an any-edge bit of 1 selects both edges.
- R11: Writes to the input, mask and status words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address, low two bits ignored |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the cycle rd_en is high |
| pin_in | input | NUM_LINES | Pad input levels (asynchronous) |
| alt_out | input | NUM_LINES | Alternate-function output value |
| alt_oe | input | NUM_LINES | Alternate-function output enable |
| pad_out | output | NUM_LINES | Pad output value |
| pad_oe | output | NUM_LINES | Pad output enable |
| irq | output | 1 | Summary interrupt |

## Verification
A corrupted mask or status bit shows on irq in the same cycle as the corruption. A status update one clock off shows up as a wrong value on the next status read, and is caught exactly at the read that races a fresh event. A synchronizer with the wrong depth makes the input word and every interrupt change one clock early or late, and this is caught at the second edge after a pin change. A wrong direction, output-enable or bypass register shows up at once on pad_oe or pad_out, right after the write that sets it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int MAX_LINES  = 32;
   localparam int W_BYPASS   = 0;
   localparam int W_DIR      = 1;
   localparam int W_OUTEN    = 2;
   localparam int W_OUTVAL   = 3;
   localparam int W_INPUT    = 4;
   localparam int W_MASK     = 5;
   localparam int W_UNMASK   = 6;
   localparam int W_SETMASK  = 7;
   localparam int W_STATUS   = 8;
   localparam int W_TYPE     = 9;
   localparam int W_POL      = 10;
   localparam int W_ANYEDGE  = 11;

   typedef enum logic [1:0] {
      TRIG_LEVEL = 2'd0,
      TRIG_EDGE1 = 2'd1,
      TRIG_EDGE2 = 2'd2
   } trig_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out,
   output logic [WIDTH-1:0] sync_prev
);
   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
         sync_prev <= '0;
      end else begin
         chain_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
         sync_prev <= chain_q[STAGES-1];
      end
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] level_now,
   input  logic [WIDTH-1:0] level_prev,
   input  logic [WIDTH-1:0] is_level,
   input  logic [WIDTH-1:0] polarity,
   input  logic [WIDTH-1:0] both_edges,
   output logic [WIDTH-1:0] hit
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_line
      trig_kind_e kind;
      logic       rise, fall;
      assign rise = level_now[i] & ~level_prev[i];
      assign fall = ~level_now[i] & level_prev[i];
      assign kind = is_level[i]   ? TRIG_LEVEL :
                    both_edges[i] ? TRIG_EDGE2 : TRIG_EDGE1;
      always_comb begin
         unique case (kind)
            TRIG_LEVEL: hit[i] = ~(level_now[i] ^ polarity[i]);
            TRIG_EDGE2: hit[i] = rise | fall;
            default:    hit[i] = polarity[i] ? rise : fall;
         endcase
      end
   end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] bypass,
   input  logic [WIDTH-1:0] dir_in,
   input  logic [WIDTH-1:0] out_en,
   input  logic [WIDTH-1:0] out_val,
   input  logic [WIDTH-1:0] alt_out,
   input  logic [WIDTH-1:0] alt_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pad
      assign pad_out[i] = bypass[i] ? alt_out[i] : out_val[i];
      assign pad_oe[i]  = bypass[i] ? alt_oe[i]  : (~dir_in[i] & out_en[i]);
   end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NUM_LINES   = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic [NUM_LINES-1:0] pin_in,
   input  logic [NUM_LINES-1:0] alt_out,
   input  logic [NUM_LINES-1:0] alt_oe,
   output logic [NUM_LINES-1:0] pad_out,
   output logic [NUM_LINES-1:0] pad_oe,
   output logic                 irq
);
   localparam int IDX_W = ADDR_W - 2;
   localparam logic [IDX_W-1:0] I_BYP  = IDX_W'(W_BYPASS);
   localparam logic [IDX_W-1:0] I_DIR  = IDX_W'(W_DIR);
   localparam logic [IDX_W-1:0] I_OEN  = IDX_W'(W_OUTEN);
   localparam logic [IDX_W-1:0] I_OVL  = IDX_W'(W_OUTVAL);
   localparam logic [IDX_W-1:0] I_INP  = IDX_W'(W_INPUT);
   localparam logic [IDX_W-1:0] I_MSK  = IDX_W'(W_MASK);
   localparam logic [IDX_W-1:0] I_UNM  = IDX_W'(W_UNMASK);
   localparam logic [IDX_W-1:0] I_SETM = IDX_W'(W_SETMASK);
   localparam logic [IDX_W-1:0] I_STS  = IDX_W'(W_STATUS);
   localparam logic [IDX_W-1:0] I_TYP  = IDX_W'(W_TYPE);
   localparam logic [IDX_W-1:0] I_POL  = IDX_W'(W_POL);
   localparam logic [IDX_W-1:0] I_ANY  = IDX_W'(W_ANYEDGE);

   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("NUM_LINES must be between 1 and %0d", MAX_LINES);
   end
   if (DATA_W < NUM_LINES) begin : g_bad_data
      $error("DATA_W must cover NUM_LINES");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must reach twelve words");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [IDX_W-1:0]     widx;
   logic [NUM_LINES-1:0] wd;
   logic [NUM_LINES-1:0] bypass_q, dir_q, oe_q, outv_q, mask_q;
   logic [NUM_LINES-1:0] status_q, type_q, pol_q, any_q;
   logic [NUM_LINES-1:0] in_sync, in_prev, hit_vec, rd_vec;
   logic                 rd_status;
   logic                 unused_bits;

   assign widx        = addr[ADDR_W-1:2];
   assign wd          = wdata[NUM_LINES-1:0];
   assign rd_status   = rd_en && (widx == I_STS);
   assign unused_bits = ^{addr[1:0], wdata};

   gpio_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pin_in),
      .sync_out(in_sync), .sync_prev(in_prev)
   );

   gpio_irq_detect #(.WIDTH(NUM_LINES)) u_detect (
      .level_now(in_sync), .level_prev(in_prev), .is_level(type_q),
      .polarity(pol_q), .both_edges(any_q), .hit(hit_vec)
   );

   gpio_pad_mux #(.WIDTH(NUM_LINES)) u_pad (
      .bypass(bypass_q), .dir_in(dir_q), .out_en(oe_q), .out_val(outv_q),
      .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bypass_q <= '0;
         dir_q    <= '1;
         oe_q     <= '0;
         outv_q   <= '0;
         mask_q   <= '1;
         type_q   <= '0;
         pol_q    <= '0;
         any_q    <= '0;
      end else if (wr_en) begin
         unique case (widx)
            I_BYP:   bypass_q <= wd;
            I_DIR:   dir_q    <= wd;
            I_OEN:   oe_q     <= wd;
            I_OVL:   outv_q   <= wd;
            I_UNM:   mask_q   <= mask_q & ~wd;
            I_SETM:  mask_q   <= mask_q | wd;
            I_TYP:   type_q   <= wd;
            I_POL:   pol_q    <= wd;
            I_ANY:   any_q    <= wd;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (rd_status ? '0 : status_q) | hit_vec;
   end

   always_comb begin
      unique case (widx)
         I_BYP:   rd_vec = bypass_q;
         I_DIR:   rd_vec = dir_q;
         I_OEN:   rd_vec = oe_q;
         I_OVL:   rd_vec = outv_q;
         I_INP:   rd_vec = in_sync;
         I_MSK:   rd_vec = mask_q;
         I_STS:   rd_vec = status_q;
         I_TYP:   rd_vec = type_q;
         I_POL:   rd_vec = pol_q;
         I_ANY:   rd_vec = any_q;
         default: rd_vec = '0;
      endcase
   end

   assign rdata = rd_en ? DATA_W'(rd_vec) : '0;
   assign irq   = |(status_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
   parameter int NUM_LINES = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic [ADDR_W-1:0]    addr,
   input logic [DATA_W-1:0]    wdata,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] status_q,
   input logic [NUM_LINES-1:0] hit_vec,
   input logic [NUM_LINES-1:0] bypass_q,
   input logic [NUM_LINES-1:0] dir_q,
   input logic [NUM_LINES-1:0] oe_q,
   input logic [NUM_LINES-1:0] alt_out,
   input logic [NUM_LINES-1:0] pad_out,
   input logic [NUM_LINES-1:0] pad_oe
);
   logic [ADDR_W-3:0] widx;
   assign widx = addr[ADDR_W-1:2];

   // R1: reset leaves every line masked and nothing pending
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (mask_q == '1 && status_q == '0));

   // R6: unmask strobe clears the written bits
   a_r6_unmask: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx == (ADDR_W-2)'(6)) |=> ((mask_q & $past(wdata[NUM_LINES-1:0])) == '0));

   // R6: mask strobe sets the written bits
   a_r6_setmask: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx == (ADDR_W-2)'(7)) |=>
      ((mask_q & $past(wdata[NUM_LINES-1:0])) == $past(wdata[NUM_LINES-1:0])));

   // R8: a status read never drops an event detected in the same clock
   a_r8_keep_new: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & $past(hit_vec)) == $past(hit_vec)));

   // R8: after a read only freshly detected events remain
   a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && widx == (ADDR_W-2)'(8)) |=> ((status_q & ~$past(hit_vec)) == '0));

   // R3: no pad driven by registers unless output direction and enabled
   a_r3_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~bypass_q & (dir_q | ~oe_q)) == '0));

   // R4: bypassed pins follow the alternate value
   a_r4_bypass_value: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & bypass_q) == (alt_out & bypass_q)));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
   .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .mask_q(mask_q), .status_q(status_q), .hit_vec(hit_vec),
   .bypass_q(bypass_q), .dir_q(dir_q), .oe_q(oe_q), .alt_out(alt_out),
   .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
   localparam int N = 24;
   localparam logic [31:0] LM = 32'h00FF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [5:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [N-1:0]  pin_in = '0, alt_out = '0, alt_oe = '0;
   logic [N-1:0]  pad_out, pad_oe;
   logic          irq;

   int n_checks = 0;
   int n_fails  = 0;
   logic [31:0] sh [12];
   logic [31:0] got;
   logic [31:0] pins;

   always #2.5 clk = ~clk;

   gpio_irq_ctrl #(.NUM_LINES(N)) u_gpio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .alt_out(alt_out),
      .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int word, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = 6'(word * 4); wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input int word, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = 6'(word * 4);
      #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pins(input logic [31:0] p);
      @(negedge clk); pins = p; pin_in = p[N-1:0];
   endtask

   function automatic logic [31:0] exp_out(input logic [31:0] bp, ov, ao);
      return (bp & ao) | (~bp & ov);
   endfunction

   function automatic logic [31:0] exp_oe(input logic [31:0] bp, dr, oe, ae);
      return ((bp & ae) | (~bp & ~dr & oe)) & LM;
   endfunction

   function automatic int rw_word(input int k);
      case (k)
         0: return 0;  1: return 1;  2: return 2;  3: return 3;
         4: return 9;  5: return 10; default: return 11;
      endcase
   endfunction

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      #(200000 * 5);
      n_fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      pins = '0;
      for (int w = 0; w < 12; w++) sh[w] = '0;
      sh[1] = LM; sh[5] = LM;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 pad_oe", 32'(pad_oe), 32'h0);
      for (int w = 0; w < 12; w++) begin
         rd(w, got);
         check($sformatf("R1 word %0d", w), got, (w == 1 || w == 5) ? LM : 32'h0);
      end

      // R2 R3 R4 R6: random register traffic with pad checks
      for (int i = 0; i < 60; i++) begin
         int k;
         logic [31:0] d;
         k = int'($urandom % 9);
         d = $urandom;
         alt_out = N'($urandom);
         alt_oe  = N'($urandom);
         if (k < 7) begin
            wr(rw_word(k), d);
            sh[rw_word(k)] = d & LM;
            rd(rw_word(k), got);
            check("R2 readback", got, sh[rw_word(k)]);
         end else if (k == 7) begin
            wr(6, d);
            sh[5] = sh[5] & ~(d & LM);
            rd(5, got);
            check("R6 unmask", got, sh[5]);
         end else begin
            wr(7, d);
            sh[5] = sh[5] | (d & LM);
            rd(5, got);
            check("R6 setmask", got, sh[5]);
         end
         check("R3 R4 pad_out", 32'(pad_out), exp_out(sh[0], sh[3], 32'(alt_out)) & LM);
         check("R3 R4 pad_oe", 32'(pad_oe), exp_oe(sh[0], sh[1], sh[2], 32'(alt_oe)));
      end
      rd(6, got); check("R2 strobe reads zero", got, 32'h0);

      // R3: direction input blocks output enable
      wr(0, 0); wr(2, LM); wr(1, LM);
      check("R3 dir input", 32'(pad_oe), 32'h0);
      wr(1, 32'h0000_00F0);
      check("R3 dir output", 32'(pad_oe), 32'h00FF_FF0F);

      // setup: rising edges everywhere, all masked, nothing pending
      wr(9, 0); wr(10, 32'hFFFF_FFFF); wr(11, 0); wr(7, 32'hFFFF_FFFF);
      idle(4); rd(8, got); rd(8, got);
      check("R8 drained", got, 32'h0);

      // R5: two-flop latency, R10 rising edges
      set_pins(32'h00A5_A5A5);
      rd(4, got); check("R5 before second edge", got, 32'h0);
      rd(4, got); check("R5 after second edge", got, 32'h00A5_A5A5);
      idle(2);
      check("R7 masked irq low", {31'b0, irq}, 32'h0);
      rd(8, got); check("R10 rising status", got, 32'h00A5_A5A5);
      rd(8, got); check("R8 cleared", got, 32'h0);

      // R8: event in the same clock as the read is kept
      wr(6, 32'h1); wr(6, 32'h2);
      set_pins(pins | 32'h2);
      @(negedge clk);
      rd(8, got); check("R8 racing read", got, 32'h0);
      check("R7 irq unmasked", {31'b0, irq}, 32'h1);
      rd(8, got); check("R8 kept bit", got, 32'h2);
      check("R7 irq after clear", {31'b0, irq}, 32'h0);

      // R6: zero bits no effect, single bit masks
      wr(7, 32'h0); rd(5, got); check("R6 zero write", got, 32'h00FF_FFFC);
      wr(7, 32'h1); rd(5, got); check("R6 mask bit0", got, 32'h00FF_FFFD);

      // R10: falling edge on bit 2
      wr(10, 32'h00FF_FFFB);
      set_pins(pins & ~32'h4); idle(4);
      rd(8, got); check("R10 falling", got, 32'h4);

      // R10: both edges on bit 3
      wr(11, 32'h8);
      set_pins(pins | 32'h8); idle(4);
      rd(8, got); check("R10 any rise", got, 32'h8);
      set_pins(pins & ~32'h8); idle(4);
      rd(8, got); check("R10 any fall", got, 32'h8);

      // R9: level high on bit 4
      wr(9, 32'h10); idle(3);
      rd(8, got); check("R9 inactive level", got, 32'h0);
      set_pins(pins | 32'h10); idle(4);
      rd(8, got); check("R9 level high", got, 32'h10);
      rd(8, got); check("R8 level reasserts", got, 32'h10);
      set_pins(pins & ~32'h10); idle(4);
      rd(8, got); rd(8, got); check("R9 level gone", got, 32'h0);

      // R9: level low on bit 6
      wr(10, 32'h00FF_FFBB); wr(9, 32'h50); idle(3);
      rd(8, got); check("R9 level low", got, 32'h40);
      set_pins(pins | 32'h40); idle(4);
      rd(8, got); rd(8, got); check("R9 level low gone", got, 32'h0);

      // R11: read-only words ignore writes
      wr(4, 32'hFFFF_FFFF); rd(4, got); check("R11 input", got, pins & LM);
      wr(8, 32'hFFFF_FFFF); rd(8, got); check("R11 status", got, 32'h0);
      wr(5, 32'h0);         rd(5, got); check("R11 mask", got, 32'h00FF_FFFD);

      summary();
      $finish;
   end
endmodule